// File: doc/BRIEF.md
# Register-Free Memory Operand Address Unit

This unit forms the linear address of a 64-bit-mode memory operand whose addressing form names no base and no index register. The caller presents the ModRM byte, the SIB byte (used only when ModRM selects one), the 32-bit displacement, the current instruction pointer, the instruction length and an optional segment override with its base. The unit then sorts the operand into one of three classes. The short no-register form is instruction-relative. The SIB form with neither base nor index is absolute. Every other form is unsupported.

The 32-bit displacement is always sign-extended to 64 bits. Instruction-relative operands add it to the address of the next instruction. An override adds the segment base in both forms. The final address is checked for canonical form. The result is registered and appears one cycle after the input strobe, together with a mode bit, a fault bit and an unsupported bit. All of these hold until the next strobe.

Top module: `direct_operand_agen`

## Requirements
- R1: `out_valid_o` is high exactly one cycle after `in_valid_i` was high. `addr_o`, `rip_rel_o`, `fault_o` and `unsup_o` change only in the cycle after a strobe, and otherwise hold their values.
- R2: When `modrm_i & 8'hC7 == 8'h05` (mod=00, rm=101), the operand is instruction-relative. In that case `rip_rel_o`=1 and the offset is `rip_i + ilen_i + sext(disp_i)`.
- R3: When `modrm_i & 8'hC7 == 8'h04` (mod=00, rm=100) and `sib_i & 8'h3F == 8'h25` (index=100, base=101), the operand is absolute. In that case `rip_rel_o`=0 and the offset is `sext(disp_i)`. The SIB scale bits [7:6] are ignored.
- R4: The displacement is sign-extended from bit 31 in both forms. For example, 0xff5ff098 gives 0xffffffffff5ff098.
- R5: With `seg_ovr_i`=1, `seg_base_i` is added to the offset in both forms. With `seg_ovr_i`=0 no base is added.
- R6: All sums wrap modulo 2^64.
- R7: `fault_o`=1 exactly when the final address (after the segment base is added) has bits 63..47 not all equal. The address is still reported on `addr_o`.
- R8: Any other ModRM/SIB combination gives `unsup_o`=1, `addr_o`=0, `fault_o`=0 and `rip_rel_o`=0.
- R9: `qword_i` (the operand-size qualifier) has no effect on any output.
- R10: After reset, all outputs are 0.
- R11: The ModRM reg field, bits [5:3], has no effect on classification or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand fields are valid this cycle |
| modrm_i | input | 8 | ModRM byte |
| sib_i | input | 8 | SIB byte, used only when rm=100 |
| disp_i | input | 32 | 32-bit displacement |
| qword_i | input | 1 | Operand-size qualifier, ignored for addressing |
| seg_ovr_i | input | 1 | A segment override applies |
| seg_base_i | input | 64 | Base of the overriding segment |
| rip_i | input | 64 | Address of the current instruction |
| ilen_i | input | 4 | Instruction length in bytes |
| out_valid_o | output | 1 | Result strobe |
| addr_o | output | 64 | Linear address |
| rip_rel_o | output | 1 | 1 = instruction-relative, 0 = absolute |
| fault_o | output | 1 | Final address is non-canonical |
| unsup_o | output | 1 | Encoding uses a register and is not handled |

## Verification
A wrong classification shows on the very next strobe as a wrong `rip_rel_o` or `unsup_o`, or as an address that is off by exactly the next-instruction pointer. A broken sign extension shows up only for displacements with bit 31 set. A broken canonical check shows up only for addresses near the bit-47 boundary. For that reason, both cases are covered on purpose, including addresses produced by a segment base and addresses that wrap past 2^64. A result register that loads without a strobe is caught in the first idle cycle, because the outputs must hold.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    FORM_ABS = 2'd0,
    FORM_RIP = 2'd1,
    FORM_BAD = 2'd2
  } form_e;
endpackage

// File: rtl/agen_classify.sv
module agen_classify
  import agen_pkg::*;
(
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  output form_e      form_o
);
  // mod and rm fields only; reg field is masked out
  localparam logic [7:0] MODRM_MASK = 8'hC7;
  localparam logic [7:0] MODRM_RIP  = 8'h05;
  localparam logic [7:0] MODRM_SIB  = 8'h04;
  // index and base fields only; scale is masked out
  localparam logic [7:0] SIB_MASK   = 8'h3F;
  localparam logic [7:0] SIB_NOREG  = 8'h25;

  logic [7:0] modrm_m;
  logic [7:0] sib_m;

  always_comb begin
    modrm_m = modrm_i & MODRM_MASK;
    sib_m   = sib_i & SIB_MASK;
    if (modrm_m == MODRM_RIP)
      form_o = FORM_RIP;
    else if (modrm_m == MODRM_SIB && sib_m == SIB_NOREG)
      form_o = FORM_ABS;
    else
      form_o = FORM_BAD;
  end
endmodule

// File: rtl/agen_sum.sv
module agen_sum
  import agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32,
  parameter int ILEN_W = 4
) (
  input  form_e              form_i,
  input  logic [DISP_W-1:0]  disp_i,
  input  logic [ADDR_W-1:0]  rip_i,
  input  logic [ILEN_W-1:0]  ilen_i,
  input  logic               seg_ovr_i,
  input  logic [ADDR_W-1:0]  seg_base_i,
  output logic [ADDR_W-1:0]  lin_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] next_ip;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] seg_add;

  always_comb begin
    disp_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    next_ip = rip_i + {{(ADDR_W-ILEN_W){1'b0}}, ilen_i};
    offset  = (form_i == FORM_RIP) ? next_ip + disp_sx : disp_sx;
    seg_add = seg_ovr_i ? seg_base_i : '0;
    lin_o   = offset + seg_add;
  end
endmodule

// File: rtl/agen_canon.sv
module agen_canon #(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              canon_o
);
  localparam int TOP_N = ADDR_W - VA_BITS;

  logic [TOP_N-1:0] diff;

  for (genvar g = 0; g < TOP_N; g++) begin : g_ext
    assign diff[g] = addr_i[VA_BITS + g] ^ addr_i[VA_BITS-1];
  end

  assign canon_o = ~|diff;
endmodule

// File: rtl/direct_operand_agen.sv
module direct_operand_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int ILEN_W  = 4,
  parameter int VA_BITS = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        modrm_i,
  input  logic [7:0]        sib_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              qword_i,
  input  logic              seg_ovr_i,
  input  logic [ADDR_W-1:0] seg_base_i,
  input  logic [ADDR_W-1:0] rip_i,
  input  logic [ILEN_W-1:0] ilen_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rip_rel_o,
  output logic              fault_o,
  output logic              unsup_o
);
  form_e             form;
  logic [ADDR_W-1:0] lin;
  logic              canon;

  agen_classify u_cls (
    .modrm_i (modrm_i),
    .sib_i   (sib_i),
    .form_o  (form)
  );

  agen_sum #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .ILEN_W(ILEN_W)) u_sum (
    .form_i     (form),
    .disp_i     (disp_i),
    .rip_i      (rip_i),
    .ilen_i     (ilen_i),
    .seg_ovr_i  (seg_ovr_i),
    .seg_base_i (seg_base_i),
    .lin_o      (lin)
  );

  agen_canon #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_canon (
    .addr_i  (lin),
    .canon_o (canon)
  );

  logic bad;
  assign bad = (form == FORM_BAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      addr_o      <= '0;
      rip_rel_o   <= 1'b0;
      fault_o     <= 1'b0;
      unsup_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        addr_o    <= bad ? '0 : lin;
        rip_rel_o <= (form == FORM_RIP);
        fault_o   <= !bad && !canon;
        unsup_o   <= bad;
      end
    end
  end

  // R1: strobe latency and hold
  a_r1_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r1_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(addr_o) && $stable(fault_o) && $stable(rip_rel_o) && $stable(unsup_o)));

  // R2 / R3: mode from the raw bytes
  a_r2_rip_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ((modrm_i & 8'hC7) == 8'h05)) |=> (rip_rel_o && !unsup_o));
  a_r3_abs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ((modrm_i & 8'hC7) == 8'h04) && ((sib_i & 8'h3F) == 8'h25))
      |=> (!rip_rel_o && !unsup_o));

  // R7: fault agrees with the reported address
  a_r7_fault_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !unsup_o) |->
      (fault_o == ((addr_o[ADDR_W-1:VA_BITS-1] != '0) && (addr_o[ADDR_W-1:VA_BITS-1] != '1))));

  // R8: unsupported results carry nothing else
  a_r8_unsup_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> (addr_o == '0 && !fault_o && !rip_rel_o));

  // R9: flipping only the size qualifier leaves the result unchanged
  a_r9_size_blind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && $past(in_valid_i) && (qword_i != $past(qword_i)) &&
     $stable(modrm_i) && $stable(sib_i) && $stable(disp_i) && $stable(seg_ovr_i) &&
     $stable(seg_base_i) && $stable(rip_i) && $stable(ilen_i))
      |=> ($stable(addr_o) && $stable(fault_o) && $stable(rip_rel_o) && $stable(unsup_o)));
endmodule

// File: tb/tb_direct_operand_agen.sv
`timescale 1ns/1ps
module tb_direct_operand_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  modrm = '0;
  logic [7:0]  sib = '0;
  logic [31:0] disp = '0;
  logic        qword = 1'b0;
  logic        seg_ovr = 1'b0;
  logic [63:0] seg_base = '0;
  logic [63:0] rip = '0;
  logic [3:0]  ilen = '0;
  logic        out_valid;
  logic [63:0] addr;
  logic        rip_rel, fault, unsup;

  always #2.5 clk = ~clk;

  direct_operand_agen dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .modrm_i(modrm), .sib_i(sib),
    .disp_i(disp), .qword_i(qword), .seg_ovr_i(seg_ovr), .seg_base_i(seg_base),
    .rip_i(rip), .ilen_i(ilen), .out_valid_o(out_valid), .addr_o(addr),
    .rip_rel_o(rip_rel), .fault_o(fault), .unsup_o(unsup)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected registered state
  logic        e_valid = 0;
  logic [63:0] e_addr  = '0;
  logic        e_rel = 0, e_fault = 0, e_unsup = 0;
  string       e_tag = "R10";

  task automatic compare();
    checks++;
    if (out_valid !== e_valid || addr !== e_addr || rip_rel !== e_rel ||
        fault !== e_fault || unsup !== e_unsup) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%h rel=%0b f=%0b u=%0b exp v=%0b a=%h rel=%0b f=%0b u=%0b",
               e_tag, out_valid, addr, rip_rel, fault, unsup,
               e_valid, e_addr, e_rel, e_fault, e_unsup);
    end
  endtask

  function automatic bit is_canon(logic [63:0] a);
    longint s;
    s = longint'(a);
    return ((s <<< 16) >>> 16) == s;
  endfunction

  task automatic model(bit v, string tag);
    longint d;
    logic [63:0] off;
    int kind; // 0 abs, 1 rip, 2 bad
    e_valid = v;
    if (!v) begin
      e_tag = {tag, " hold R1"};
      return;
    end
    e_tag = tag;
    if ((modrm & 8'hC7) == 8'h05) kind = 1;
    else if ((modrm & 8'hC7) == 8'h04 && (sib & 8'h3F) == 8'h25) kind = 0;
    else kind = 2;
    d = int'(disp);
    off = (kind == 1) ? rip + 64'(ilen) + d : d;
    if (seg_ovr) off = off + seg_base;
    if (kind == 2) begin
      e_addr = '0; e_rel = 0; e_fault = 0; e_unsup = 1;
    end else begin
      e_addr = off; e_rel = (kind == 1); e_fault = !is_canon(off); e_unsup = 0;
    end
  endtask

  task automatic tick(bit v, logic [7:0] m, logic [7:0] s, logic [31:0] dd,
                      bit ov, logic [63:0] sb, logic [63:0] ip, logic [3:0] il,
                      bit q, string tag);
    @(negedge clk);
    if (!done) compare();
    in_valid = v; modrm = m; sib = s; disp = dd; seg_ovr = ov;
    seg_base = sb; rip = ip; ilen = il; qword = q;
    model(v, tag);
  endtask

  task automatic idle(string tag);
    tick(0, 8'hAA, 8'h55, 32'hDEAD_BEEF, 1, 64'h1234, 64'h9999, 4'd7, 1, tag);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (2) @(negedge clk);
    compare();
    @(negedge clk);
    rst_n = 1'b1;
    e_tag = "R10";

    // R3 R4 absolute with sign extension
    tick(1, 8'h04, 8'h25, 32'hff5f_f098, 0, 0, 64'h40_0000, 4'd8, 1, "R3 R4 abs");
    // R2 R4 RIP-relative, negative displacement
    tick(1, 8'h05, 8'h00, 32'hffff_fee7, 0, 0, 64'h40_01c6, 4'd8, 1, "R2 R4 rip neg");
    // R5 override on absolute
    tick(1, 8'h04, 8'h25, 32'h0040_00b5, 1, 64'h0000_7f00_0000_0000, 0, 4'd9, 1, "R5 abs seg");
    // R5 override on RIP-relative
    tick(1, 8'h05, 8'h11, 32'h0000_0100, 1, 64'h0000_0010_0000_0000, 64'h1000, 4'd7, 0, "R5 rip seg");
    idle("R1");
    idle("R1");
    // R7 non-canonical via segment base
    tick(1, 8'h04, 8'h25, 32'h0000_0010, 1, 64'h0000_8000_0000_0000, 0, 4'd8, 0, "R7 noncanon");
    // R7 upper boundary canonical
    tick(1, 8'h04, 8'h25, 32'h0000_0000, 1, 64'hffff_8000_0000_0000, 0, 4'd8, 0, "R7 edge ok");
    tick(1, 8'h04, 8'h25, 32'hffff_ffff, 1, 64'hffff_8000_0000_0000, 0, 4'd8, 0, "R7 edge fault");
    // R6 wrap
    tick(1, 8'h05, 8'h00, 32'h0000_0020, 0, 0, 64'hffff_ffff_ffff_fff0, 4'd15, 0, "R6 wrap");
    // R8 unsupported forms
    tick(1, 8'h45, 8'h25, 32'h0000_1000, 0, 0, 64'h2000, 4'd6, 0, "R8 mod01 rm101");
    tick(1, 8'h04, 8'h24, 32'h0000_1000, 0, 0, 64'h2000, 4'd6, 0, "R8 sib base rsp");
    tick(1, 8'h04, 8'h05, 32'h0000_1000, 0, 0, 64'h2000, 4'd6, 0, "R8 sib index");
    tick(1, 8'h00, 8'h25, 32'h0000_1000, 0, 0, 64'h2000, 4'd6, 0, "R8 mod00 rm000");
    tick(1, 8'hc5, 8'h25, 32'h0000_1000, 0, 0, 64'h2000, 4'd6, 0, "R8 mod11");
    idle("R8");
    // R11 reg field ignored, R3 scale ignored
    tick(1, 8'h3d, 8'h00, 32'h8000_0000, 0, 0, 64'h5000, 4'd5, 0, "R11 reg rip");
    tick(1, 8'h1c, 8'he5, 32'h7fff_ffff, 0, 0, 64'h5000, 4'd5, 0, "R11 R3 scale");
    // R9 size qualifier flip
    tick(1, 8'h05, 8'h00, 32'h0000_0040, 1, 64'h77, 64'h3000, 4'd3, 0, "R9 q0");
    tick(1, 8'h05, 8'h00, 32'h0000_0040, 1, 64'h77, 64'h3000, 4'd3, 1, "R9 q1");
    idle("R9");

    // mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [7:0] m;
      logic [7:0] s;
      int pick;
      pick = $urandom_range(0, 3);
      case (pick)
        0: m = 8'h05 | (8'($urandom_range(0, 7)) << 3);
        1: m = 8'h04 | (8'($urandom_range(0, 7)) << 3);
        default: m = 8'($urandom);
      endcase
      s = ($urandom_range(0, 2) != 0) ? (8'h25 | (8'($urandom_range(0, 3)) << 6)) : 8'($urandom);
      tick($urandom_range(0, 3) != 0, m, s, $urandom, $urandom_range(0, 1),
           {$urandom, $urandom}, {$urandom, $urandom}, 4'($urandom), $urandom_range(0, 1),
           "R2 R3 R5 R7 sweep");
    end
    idle("R1");
    @(negedge clk);
    compare();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule